// File: doc/BRIEF.md
# Interval Timer Host Register File

This block is the host-facing register file of a three-channel interval timer. The host sees four byte-wide locations. Locations 0 to 2 carry the count data of channels 0 to 2, and location 3 takes control words. A control word either selects how one channel's count is transferred, together with that channel's mode and decimal flag, or it freezes that channel's running count so that it can be read without tearing.

Initial counts are built from one or two byte writes, depending on the channel's transfer pattern. When the last byte of the pattern arrives, the channel receives a one-cycle load strobe and the full 16-bit value. Reads return bytes of the live count, or of the frozen copy while one is held. The counting logic sits outside this block. It supplies the live counts and consumes the load, control and mode outputs.

Top module: `tmr_host_regs`

## Requirements
- R1: After reset, no load or control strobe is active, every channel reports mode 0 with the decimal flag clear, and every channel uses the low-byte-only pattern.
- R2: A write to location 3 whose bits 7:6 are 0, 1 or 2 and whose bits 5:4 are not 00 addresses that channel. In the next cycle that channel's mode output equals bits 3:1 and its decimal flag equals bit 0. Its control strobe is high for that one cycle, and both of its byte toggles are cleared.
- R3: A control write with bits 7:6 = 11 raises no strobe and leaves every mode and decimal output unchanged.
- R4: Pattern 01 (low byte only): a data write raises the load strobe in the next cycle with the value {8'h00, byte}, and a read returns bits 7:0 of the count.
- R5: Pattern 10 (high byte only): a data write loads {byte, 8'h00}, and a read returns bits 15:8.
- R6: Pattern 11 (low then high): the first data write stores the byte and raises no strobe. The second write loads {second, first}. Reads alternate between the low byte and the high byte, starting with the low byte.
- R7: A control word with bits 5:4 = 00 freezes the selected channel's live count. Reads then return bytes of the frozen value while the live count moves on. The hold is released once the value has been read out in full under the current pattern: one read for patterns 01 and 10, two reads for pattern 11. Later reads return the live count.
- R8: A freeze command for a channel that already holds a frozen value is ignored.
- R9: A read of location 3 returns 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Register location 0..3 |
| wdata | input | 8 | Write byte |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (advances read sequencing) |
| live_cnt | input | 48 | Live counts, channel i in bits 16i+15:16i |
| rdata | output | 8 | Read byte for addr (combinational) |
| ld_stb | output | 3 | Per-channel one-cycle load strobe |
| ld_val | output | 48 | Per-channel loaded count, channel i in bits 16i+15:16i |
| ctl_stb | output | 3 | Per-channel pulse on an accepted control word |
| ch_mode | output | 9 | Per-channel 3-bit mode, channel i in bits 3i+2:3i |
| ch_bcd | output | 3 | Per-channel decimal-count flag |

## Verification
The bench targets the byte toggle in the two-byte pattern, where a design that failed to clear it on a control word would load a half-formed value or return the high byte first. It freezes a count and then changes the live value between reads, so that a design that tore the read or released the hold too early is caught. It repeats freeze commands while a value is held: a design that accepted the second one would return the newer count. Control words with select 11 are mixed in to expose any design that treated them as channel writes.

// File: rtl/tmr_host_regs.sv
module tmr_host_regs (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  addr,
  input  logic [7:0]  wdata,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [47:0] live_cnt,
  output logic [7:0]  rdata,
  output logic [2:0]  ld_stb,
  output logic [47:0] ld_val,
  output logic [2:0]  ctl_stb,
  output logic [8:0]  ch_mode,
  output logic [2:0]  ch_bcd
);
  localparam int NCH = 3;
  localparam int CW  = 16;
  localparam logic [1:0] AC_LATCH = 2'd0, AC_LO = 2'd1, AC_HI = 2'd2, AC_BOTH = 2'd3;
  localparam logic [1:0] CTL_ADDR = 2'd3;

  logic [1:0]    acc_q  [NCH];
  logic [2:0]    mode_q [NCH];
  logic          bcd_q  [NCH];
  logic          wtog_q [NCH];
  logic          rtog_q [NCH];
  logic          held_q [NCH];
  logic          ld_q   [NCH];
  logic          cs_q   [NCH];
  logic [7:0]    lo_q   [NCH];
  logic [CW-1:0] hold_q [NCH];
  logic [CW-1:0] val_q  [NCH];
  logic [7:0]    rbyte  [4];

  wire ctl_wr = wr_en && addr == CTL_ADDR && wdata[7:6] != 2'd3;

  assign rbyte[3] = 8'h00;
  assign rdata    = rbyte[addr];

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    wire           sel_ctl = ctl_wr && wdata[7:6] == 2'(i);
    wire           dwr     = wr_en && addr == 2'(i);
    wire           drd     = rd_en && addr == 2'(i);
    wire           last_rd = acc_q[i] != AC_BOTH || rtog_q[i];
    wire [CW-1:0]  src     = held_q[i] ? hold_q[i] : live_cnt[CW*i +: CW];
    wire           rd_hi   = acc_q[i] == AC_HI || (acc_q[i] == AC_BOTH && rtog_q[i]);

    assign rbyte[i]          = rd_hi ? src[15:8] : src[7:0];
    assign ld_stb[i]         = ld_q[i];
    assign ctl_stb[i]        = cs_q[i];
    assign ld_val[CW*i +: CW] = val_q[i];
    assign ch_mode[3*i +: 3] = mode_q[i];
    assign ch_bcd[i]         = bcd_q[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        acc_q[i]  <= AC_LO;
        mode_q[i] <= 3'd0;
        bcd_q[i]  <= 1'b0;
        wtog_q[i] <= 1'b0;
        rtog_q[i] <= 1'b0;
        held_q[i] <= 1'b0;
        ld_q[i]   <= 1'b0;
        cs_q[i]   <= 1'b0;
        lo_q[i]   <= 8'h00;
        hold_q[i] <= '0;
        val_q[i]  <= '0;
      end else begin
        ld_q[i] <= 1'b0;
        cs_q[i] <= 1'b0;
        if (sel_ctl && wdata[5:4] == AC_LATCH) begin
          if (!held_q[i]) begin
            held_q[i] <= 1'b1;
            hold_q[i] <= live_cnt[CW*i +: CW];
            rtog_q[i] <= 1'b0;
          end
        end else if (sel_ctl) begin
          acc_q[i]  <= wdata[5:4];
          mode_q[i] <= wdata[3:1];
          bcd_q[i]  <= wdata[0];
          wtog_q[i] <= 1'b0;
          rtog_q[i] <= 1'b0;
          held_q[i] <= 1'b0;
          cs_q[i]   <= 1'b1;
        end else begin
          if (dwr) begin
            case (acc_q[i])
              AC_LO: begin
                ld_q[i]  <= 1'b1;
                val_q[i] <= {8'h00, wdata};
              end
              AC_HI: begin
                ld_q[i]  <= 1'b1;
                val_q[i] <= {wdata, 8'h00};
              end
              AC_BOTH: begin
                if (!wtog_q[i]) begin
                  lo_q[i]   <= wdata;
                  wtog_q[i] <= 1'b1;
                end else begin
                  ld_q[i]   <= 1'b1;
                  val_q[i]  <= {wdata, lo_q[i]};
                  wtog_q[i] <= 1'b0;
                end
              end
              default: ;
            endcase
          end
          if (drd) begin
            if (acc_q[i] == AC_BOTH) rtog_q[i] <= ~rtog_q[i];
            if (held_q[i] && last_rd) held_q[i] <= 1'b0;
          end
        end
      end
    end

    AST_LOAD_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      ld_stb[i] |-> $past(wr_en && addr == 2'(i))); // R4
    AST_LOW_ONLY_HI_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_stb[i] && acc_q[i] == AC_LO) |-> ld_val[CW*i+8 +: 8] == 8'h00); // R4
    AST_FIRST_BYTE_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      $past(dwr && acc_q[i] == AC_BOTH && !wtog_q[i]) |-> !ld_stb[i]); // R6
    AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(held_q[i]) && held_q[i]) |-> $stable(hold_q[i])); // R8
  end

  AST_SEL3_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en && addr == CTL_ADDR && wdata[7:6] == 2'd3)
      |-> (ctl_stb == 3'b000 && $stable(ch_mode) && $stable(ch_bcd))); // R3
  AST_ONE_CTL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ctl_stb)); // R2
endmodule

// File: tb/sim_tmr_host_regs.sv
module sim_tmr_host_regs;
  localparam int CLK_P = 10;
  localparam int NOPS  = 700;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [7:0]  wdata = 8'h00;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [15:0] live [3];
  logic [47:0] live_cnt;
  logic [7:0]  rdata;
  logic [2:0]  ld_stb, ctl_stb, ch_bcd;
  logic [47:0] ld_val;
  logic [8:0]  ch_mode;

  assign live_cnt = {live[2], live[1], live[0]};
  always #(CLK_P/2) clk = ~clk;

  tmr_host_regs u0 (.clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .rd_en(rd_en), .live_cnt(live_cnt), .rdata(rdata), .ld_stb(ld_stb), .ld_val(ld_val),
    .ctl_stb(ctl_stb), .ch_mode(ch_mode), .ch_bcd(ch_bcd));

  int checks = 0, failures = 0;
  int acc [3], wt [3], rt [3], hd [3];
  logic [15:0] hv [3];
  logic [7:0]  lo [3];
  logic [2:0]  md [3];
  logic        bc [3];

  task automatic chk(string tag, logic [47:0] got, logic [47:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic logic [8:0] exp_modes();
    return {md[2], md[1], md[0]};
  endfunction

  function automatic logic [2:0] exp_bcds();
    return {bc[2], bc[1], bc[0]};
  endfunction

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_ctl(logic [7:0] d);
    int s;
    logic [8:0] pm;
    logic [2:0] pb;
    pm = ch_mode; pb = ch_bcd;
    wr(2'd3, d);
    s = int'(d[7:6]);
    if (s == 3) begin
      chk("R3 ctl_stb", 48'(ctl_stb), 48'd0);
      chk("R3 mode", 48'({pm, pb}), 48'({ch_mode, ch_bcd}));
    end else if (d[5:4] == 2'b00) begin
      if (hd[s] == 0) begin hd[s] = 1; hv[s] = live[s]; rt[s] = 0; end
      chk("R7 latch no ctl_stb", 48'(ctl_stb), 48'd0);
    end else begin
      acc[s] = int'(d[5:4]); md[s] = d[3:1]; bc[s] = d[0];
      wt[s] = 0; rt[s] = 0; hd[s] = 0;
      chk("R2 ctl_stb", 48'(ctl_stb), 48'(3'b001 << s));
      chk("R2 mode", 48'({ch_mode, ch_bcd}), 48'({exp_modes(), exp_bcds()}));
    end
  endtask

  task automatic do_wr(int c, logic [7:0] d);
    logic [15:0] ev;
    logic        es;
    string       tag;
    es = 1'b0; ev = 16'h0;
    case (acc[c])
      1: begin es = 1'b1; ev = {8'h00, d}; tag = "R4"; end
      2: begin es = 1'b1; ev = {d, 8'h00}; tag = "R5"; end
      default: begin
        tag = "R6";
        if (wt[c] == 0) begin lo[c] = d; wt[c] = 1; end
        else begin es = 1'b1; ev = {d, lo[c]}; wt[c] = 0; end
      end
    endcase
    wr(2'(c), d);
    chk({tag, " ld_stb"}, 48'(ld_stb), 48'(es ? (3'b001 << c) : 3'b000));
    if (es) chk({tag, " ld_val"}, 48'(ld_val[16*c +: 16]), 48'(ev));
  endtask

  task automatic do_rd(int c);
    logic [15:0] sv;
    logic [7:0]  eb;
    logic        hi;
    string       tag;
    @(negedge clk);
    addr = 2'(c); rd_en = 1'b1;
    #1;
    if (c == 3) begin
      chk("R9 rdata", 48'(rdata), 48'd0);
    end else begin
      sv  = (hd[c] != 0) ? hv[c] : live[c];
      hi  = (acc[c] == 2) || (acc[c] == 3 && rt[c] != 0);
      eb  = hi ? sv[15:8] : sv[7:0];
      tag = (hd[c] != 0) ? "R7" : (acc[c] == 1) ? "R4" : (acc[c] == 2) ? "R5" : "R6";
      chk({tag, " rdata"}, 48'(rdata), 48'(eb));
      if (hd[c] != 0 && (acc[c] != 3 || rt[c] != 0)) hd[c] = 0;
      if (acc[c] == 3) rt[c] = 1 - rt[c];
    end
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  initial begin
    #(CLK_P * 150000);
    failures++;
    $display("FAIL watchdog");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 3; i++) begin
      acc[i] = 1; wt[i] = 0; rt[i] = 0; hd[i] = 0; hv[i] = '0; lo[i] = '0;
      md[i] = '0; bc[i] = 1'b0; live[i] = 16'h1200 + 16'(i);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 strobes", 48'({ld_stb, ctl_stb}), 48'd0);
    chk("R1 modes", 48'({ch_mode, ch_bcd}), 48'd0);
    do_rd(0);
    do_wr(1, 8'h5a);

    do_ctl(8'b01_11_010_1);
    do_wr(1, 8'h34);
    do_wr(1, 8'h12);
    do_wr(1, 8'hcd);
    do_ctl(8'b01_11_011_0);
    do_wr(1, 8'h78);
    do_wr(1, 8'h56);
    do_ctl(8'b10_10_100_0);
    do_wr(2, 8'h9e);
    do_ctl(8'b11_01_111_1);
    do_rd(3);

    do_ctl(8'b00_11_000_0);
    live[0] = 16'hbeef;
    do_ctl(8'b00_00_000_0);
    live[0] = 16'h1111;
    do_ctl(8'b00_00_000_0);
    live[0] = 16'h2222;
    do_rd(0);
    live[0] = 16'h3333;
    do_rd(0);
    do_rd(0);
    do_rd(0);

    for (int n = 0; n < NOPS; n++) begin
      int op;
      int c;
      op = int'($urandom_range(0, 9));
      c  = int'($urandom_range(0, 2));
      if (op < 2) do_ctl(8'($urandom));
      else if (op < 3) do_ctl({2'(c), 2'b00, 4'($urandom)});
      else if (op < 6) do_wr(c, 8'($urandom));
      else if (op < 9) do_rd(c);
      else live[c] = 16'($urandom);
      if (op == 8) do_rd(3);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule